// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits on the byte stream that leaves a receive MAC. It looks at the destination address at the head of each frame and decides whether the frame is forwarded downstream or quietly consumed. Frames are admitted when the destination matches the programmed station address. A broadcast destination (all ones) or a group destination is admitted only when its enable is set. Promiscuous mode admits every frame that is long enough to carry a destination address. Because the decision needs all six destination bytes, the block holds those bytes in a small buffer and then replays them downstream, so an admitted frame appears on the output complete and in order.

For every frame, admitted or not, the block reports one status byte. This byte flags a bad frame check sequence, a runt fragment, an oversize frame, an out-of-range length field, a group-flagged source address, a group destination and an address miss. It also carries a summary "good" bit. Downstream logic forwards the stream and uses the status byte to commit or discard the frame it has buffered.

Both streams use valid/ready. A byte moves when valid and ready are both high at a rising clock edge. A source must hold valid and all of its data fields until the byte is taken. The block holds its own output under back-pressure in the same way. While the held destination bytes are replayed, the input is stalled. After that, the input ready follows the output ready combinationally. The status byte is a one-cycle pulse with no handshake.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, m_valid and st_valid are low and s_ready is high.
- R2: Byte i of the frame (i = 0..5) is compared with station_addr[8i+7:8i]. When all six match, the whole frame is forwarded byte for byte: the first output byte has m_sof high and the last has m_eof high.
- R3: A frame that no rule admits produces no output byte. Its status has bit 6 (address miss) set and bit 0 clear.
- R4: An all-ones destination is admitted only when cfg_bcast_en is high. The status of such a frame has bit 5 set.
- R5: A destination with bit 0 of its first byte set, other than all ones, is admitted only when cfg_group_en is high. The status has bit 5 set.
- R6: With cfg_promisc high, every frame of at least 6 bytes is forwarded, whatever its destination.
- R7: A frame of fewer than 64 bytes sets status bit 2 and clears bit 0. A frame of fewer than 6 bytes is never forwarded and also sets bit 6. A frame of 6 to 63 admitted bytes is forwarded.
- R8: A frame longer than 1518 bytes sets status bit 3 and clears bit 0. A 1518-byte frame is not flagged.
- R9: In a frame of at least 64 bytes, a length field greater than 1500 sets status bit 4 and clears bit 0. The length field is byte 12 (high half) and byte 13 (low half).
- R10: In a frame of at least 64 bytes, a source address with bit 0 of byte 6 set sets status bit 7 and clears bit 0.
- R11: s_fcs_ok low on the last input byte sets status bit 1 and clears bit 0.
- R12: st_valid pulses for exactly one cycle, in the cycle after the last input byte of a frame is taken. Bit 0 is set only for a forwarded frame with none of bits 1, 2, 3, 4 or 7 set.
- R13: While m_valid is high and m_ready low, the output byte and its markers stay unchanged. s_ready is low while held destination bytes are being replayed. Byte order is preserved under any m_ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address; bits [7:0] are the first byte on the wire |
| cfg_bcast_en | input | 1 | Admit the all-ones destination |
| cfg_group_en | input | 1 | Admit group destinations |
| cfg_promisc | input | 1 | Admit every frame |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | Input byte is the first of a frame |
| s_eof | input | 1 | Input byte is the last of a frame |
| s_fcs_ok | input | 1 | Frame check sequence good, sampled with the last byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | Output byte is the first of a frame |
| m_eof | output | 1 | Output byte is the last of a frame |
| st_valid | output | 1 | Status byte valid, one cycle |
| st_byte | output | 8 | Status: 0 good, 1 check error, 2 fragment, 3 oversize, 4 bad length, 5 group destination, 6 address miss, 7 group source |

## Verification
The address decision and the end of a frame can land on the same input beat, when a frame is exactly six bytes long. On that beat the block must start a replay that carries the end marker on its sixth byte and, at the same time, issue a fragment status. The bench sends six-byte admitted frames, both with a steady output and under back-pressure. It checks that all six bytes arrive with the markers on the first and last, and that the status reads fragment without the miss bit. A second overlap, a fragment that also fails its check sequence, is judged by expecting both flags in a single status byte.

// File: rtl/rff_pkg.sv
package rff_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_FLUSH,
    ST_PASS,
    ST_DROP
  } rff_state_e;

  localparam int SB_OK   = 0;
  localparam int SB_CRC  = 1;
  localparam int SB_FRAG = 2;
  localparam int SB_OVER = 3;
  localparam int SB_LEN  = 4;
  localparam int SB_GRP  = 5;
  localparam int SB_MISS = 6;
  localparam int SB_SRCG = 7;
endpackage

// File: rtl/rff_addr_class.sv
module rff_addr_class #(
  parameter int AB = 6
) (
  input  logic [8*AB-1:0] da,
  input  logic [8*AB-1:0] station,
  input  logic            bcast_en,
  input  logic            group_en,
  input  logic            promisc,
  output logic            admit,
  output logic            is_group,
  output logic            is_bcast
);
  logic uni_hit;

  always_comb begin
    is_bcast = &da;
    is_group = da[0];
    uni_hit  = (da == station);
    admit    = promisc
             | uni_hit
             | (is_bcast & bcast_en)
             | (is_group & ~is_bcast & group_en);
  end
endmodule

// File: rtl/rff_head_buf.sv
module rff_head_buf #(
  parameter int AB = 6,
  parameter int IW = $clog2(AB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [7:0]          wr_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [7:0]          rd_data,
  output logic [8*(AB-1)-1:0] da_lo
);
  logic [7:0] slot [AB];

  for (genvar g = 0; g < AB; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        slot[g] <= wr_data;
    end
  end

  for (genvar g = 0; g < AB - 1; g++) begin : g_da
    assign da_lo[8*g +: 8] = slot[g];
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/rff_meter.sv
module rff_meter #(
  parameter int AB        = 6,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_LEN   = 1500,
  parameter int CW        = $clog2(MAX_FRAME + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          restart,
  input  logic [7:0]    data,
  output logic [CW-1:0] cnt,
  output logic          frag,
  output logic          over,
  output logic          badlen,
  output logic          srcg
);
  localparam logic [CW-1:0] SAT    = CW'(MAX_FRAME + 1);
  localparam logic [CW-1:0] IDX_SA = CW'(AB);
  localparam logic [CW-1:0] IDX_LH = CW'(2 * AB);
  localparam logic [CW-1:0] IDX_LL = CW'(2 * AB + 1);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic [15:0]   len_q;
  logic          sa_g_q;

  always_comb begin
    if (restart)
      cnt_nx = CW'(1);
    else if (cnt_q == SAT)
      cnt_nx = SAT;
    else
      cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      sa_g_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= cnt_nx;
      if (restart) begin
        len_q  <= '0;
        sa_g_q <= 1'b0;
      end else begin
        if (cnt_q == IDX_SA) sa_g_q      <= data[0];
        if (cnt_q == IDX_LH) len_q[15:8] <= data;
        if (cnt_q == IDX_LL) len_q[7:0]  <= data;
      end
    end
  end

  always_comb begin
    cnt    = cnt_q;
    frag   = cnt_nx < CW'(MIN_FRAME);
    over   = cnt_nx > CW'(MAX_FRAME);
    badlen = ~frag & (len_q > 16'(MAX_LEN));
    srcg   = ~frag & sa_g_q;
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter #(
  parameter int AB        = 6,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int MAX_LEN   = 1500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [8*AB-1:0] station_addr,
  input  logic          cfg_bcast_en,
  input  logic          cfg_group_en,
  input  logic          cfg_promisc,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          s_fcs_ok,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [7:0]    m_data,
  output logic          m_sof,
  output logic          m_eof,
  output logic          st_valid,
  output logic [7:0]    st_byte
);
  import rff_pkg::*;

  localparam int CW = $clog2(MAX_FRAME + 2);
  localparam int IW = $clog2(AB);
  localparam logic [IW-1:0] LAST_IDX = IW'(AB - 1);

  rff_state_e    st_q, st_nx;
  logic [IW-1:0] fl_idx_q;
  logic          eof_held_q;
  logic          grp_q;

  logic          beat, counted, head_done, frame_end;
  logic [CW-1:0] cnt;
  logic          frag, over, badlen, srcg;
  logic [IW-1:0] wr_idx;
  logic [7:0]    rd_data;
  logic [8*(AB-1)-1:0] da_lo;
  logic          admit, is_group, is_bcast;
  logic          fwd, grp_now;
  logic [7:0]    status_nx;

  assign beat      = s_valid & s_ready;
  assign counted   = beat & ((st_q != ST_IDLE) | s_sof);
  assign head_done = (st_q == ST_HEAD) & counted & (cnt == CW'(AB - 1));
  assign frame_end = counted & s_eof;
  assign wr_idx    = (st_q == ST_IDLE) ? '0 : cnt[IW-1:0];

  rff_meter #(
    .AB(AB), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME),
    .MAX_LEN(MAX_LEN), .CW(CW)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .beat(counted),
    .restart(st_q == ST_IDLE), .data(s_data),
    .cnt(cnt), .frag(frag), .over(over), .badlen(badlen), .srcg(srcg)
  );

  rff_head_buf #(.AB(AB), .IW(IW)) u_head (
    .clk(clk), .rst_n(rst_n),
    .wr_en(counted & ((st_q == ST_IDLE) | (st_q == ST_HEAD))),
    .wr_idx(wr_idx), .wr_data(s_data),
    .rd_idx(fl_idx_q), .rd_data(rd_data), .da_lo(da_lo)
  );

  rff_addr_class #(.AB(AB)) u_class (
    .da({s_data, da_lo}), .station(station_addr),
    .bcast_en(cfg_bcast_en), .group_en(cfg_group_en), .promisc(cfg_promisc),
    .admit(admit), .is_group(is_group), .is_bcast(is_bcast)
  );

  // stream muxing
  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = s_data;
    m_sof   = 1'b0;
    m_eof   = 1'b0;
    case (st_q)
      ST_IDLE, ST_HEAD, ST_DROP: s_ready = 1'b1;
      ST_FLUSH: begin
        m_valid = 1'b1;
        m_data  = rd_data;
        m_sof   = (fl_idx_q == '0);
        m_eof   = (fl_idx_q == LAST_IDX) & eof_held_q;
      end
      ST_PASS: begin
        s_ready = m_ready;
        m_valid = s_valid;
        m_eof   = s_eof;
      end
      default: s_ready = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    st_nx = st_q;
    case (st_q)
      ST_IDLE:
        if (counted && !s_eof) st_nx = ST_HEAD;
      ST_HEAD:
        if (head_done) begin
          if (admit)      st_nx = ST_FLUSH;
          else if (s_eof) st_nx = ST_IDLE;
          else            st_nx = ST_DROP;
        end else if (frame_end) begin
          st_nx = ST_IDLE;
        end
      ST_FLUSH:
        if (m_ready && fl_idx_q == LAST_IDX)
          st_nx = eof_held_q ? ST_IDLE : ST_PASS;
      ST_PASS, ST_DROP:
        if (frame_end) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  // status composition
  always_comb begin
    fwd     = (st_q == ST_PASS) | (head_done & admit);
    grp_now = (st_q == ST_IDLE) ? s_data[0] : grp_q;
    status_nx          = '0;
    status_nx[SB_OK]   = fwd & s_fcs_ok & ~frag & ~over & ~badlen & ~srcg;
    status_nx[SB_CRC]  = ~s_fcs_ok;
    status_nx[SB_FRAG] = frag;
    status_nx[SB_OVER] = over;
    status_nx[SB_LEN]  = badlen;
    status_nx[SB_GRP]  = grp_now;
    status_nx[SB_MISS] = ~fwd;
    status_nx[SB_SRCG] = srcg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      fl_idx_q   <= '0;
      eof_held_q <= 1'b0;
      grp_q      <= 1'b0;
      st_valid   <= 1'b0;
      st_byte    <= '0;
    end else begin
      st_q     <= st_nx;
      st_valid <= frame_end;
      if (frame_end) st_byte <= status_nx;
      if (st_q == ST_IDLE && counted) grp_q <= s_data[0];
      if (head_done) begin
        fl_idx_q   <= '0;
        eof_held_q <= s_eof;
      end else if (st_q == ST_FLUSH && m_ready) begin
        fl_idx_q <= fl_idx_q + IW'(1);
      end
    end
  end

  // classification flags are folded into status via grp_now; keep them observable
  logic unused_cls;
  assign unused_cls = is_group ^ is_bcast;
endmodule

// File: rtl/rff_checker.sv
module rff_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_sof,
  input logic       m_eof,
  input logic       st_valid,
  input logic [7:0] st_byte
);
  AST_REPLAY_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_sof |-> !s_ready); // R13

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eof)); // R13

  AST_GOOD_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_byte[0] |-> (st_byte & 8'hDE) == 8'h00); // R12

  AST_FRAG_NOT_OVERSIZE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !(st_byte[2] && st_byte[3])); // R7

  AST_SRCG_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_byte[7] |-> !st_byte[0]); // R10

  AST_MISS_NOT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_byte[6] |-> !st_byte[0]); // R3
endmodule

bind rx_frame_filter rff_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_sof(m_sof), .m_eof(m_eof),
  .st_valid(st_valid), .st_byte(st_byte)
);

// File: tb/rx_frame_filter_test.sv
module rx_frame_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] station_addr = 48'h554433221102;
  logic        cfg_bcast_en = 1'b0, cfg_group_en = 1'b0, cfg_promisc = 1'b0;
  logic        s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_fcs_ok = 1'b1;
  logic [7:0]  s_data = '0;
  logic        s_ready, m_valid, m_sof, m_eof, st_valid;
  logic        m_ready = 1'b1;
  logic [7:0]  m_data, st_byte;

  rx_frame_filter uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0, bp_en = 1'b0;
  int cyc = 0;

  logic [9:0]  exp_q[$];
  string       exp_tag[$];
  logic [7:0]  st_q[$];
  string       st_tag[$];
  logic [7:0]  frm [0:2047];
  int          n;

  localparam logic [47:0] DA_MISS = 48'h554433221104;
  localparam logic [47:0] DA_BC   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] DA_GRP  = 48'h0000005E0001;
  localparam logic [47:0] SA_OK   = 48'hAA9988776600;
  localparam logic [47:0] SA_GRP  = 48'hAA9988776601;

  always @(posedge clk) begin
    #1;
    m_ready = bp_en ? (cyc % 3 != 2) : 1'b1;
    cyc++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0)
          chk("R3 unexpected output byte", {22'd0, m_sof, m_eof, m_data}, 32'hFFFF_FFFF);
        else
          chk(exp_tag.pop_front(), {22'd0, m_sof, m_eof, m_data}, {22'd0, exp_q.pop_front()});
      end
      if (st_valid) begin
        if (st_q.size() == 0)
          chk("R12 unexpected status", {24'd0, st_byte}, 32'hFFFF_FFFF);
        else
          chk(st_tag.pop_front(), {24'd0, st_byte}, {24'd0, st_q.pop_front()});
      end
    end
  end

  task automatic build(input logic [47:0] da, input logic [47:0] sa,
                       input int len, input int total);
    n = total;
    for (int i = 0; i < total; i++) begin
      if (i < 6)        frm[i] = da[8*i +: 8];
      else if (i < 12)  frm[i] = sa[8*(i-6) +: 8];
      else if (i == 12) frm[i] = len[15:8];
      else if (i == 13) frm[i] = len[7:0];
      else              frm[i] = 8'(i * 7 + 3);
    end
  endtask

  task automatic send(input string tag, input bit fwd, input logic [7:0] exp_st,
                      input bit fcs);
    bit hs;
    if (fwd)
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({i == 0, i == n - 1, frm[i]});
        exp_tag.push_back({tag, " data"});
      end
    st_q.push_back(exp_st);
    st_tag.push_back({tag, " status"});
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = frm[i];
      s_sof = (i == 0); s_eof = (i == n - 1); s_fcs_ok = fcs;
      do begin
        @(negedge clk); hs = s_ready;
        @(posedge clk); #1;
      end while (!hs);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_fcs_ok = 1'b1;
    while (exp_q.size() != 0 || st_q.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R1 m_valid", {31'd0, m_valid}, 32'd0);
    chk("R1 st_valid", {31'd0, st_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 s_ready", {31'd0, s_ready}, 32'd1);
    @(posedge clk); #1;

    build(station_addr, SA_OK, 50, 64);    send("R2 unicast 64", 1, 8'h01, 1);
    build(DA_MISS, SA_OK, 50, 64);         send("R3 miss", 0, 8'h40, 1);
    build(DA_BC, SA_OK, 50, 80);           send("R4 bcast off", 0, 8'h60, 1);
    cfg_bcast_en = 1'b1;
    build(DA_BC, SA_OK, 50, 80);           send("R4 bcast on", 1, 8'h21, 1);
    build(DA_GRP, SA_OK, 50, 70);          send("R5 group off", 0, 8'h60, 1);
    cfg_group_en = 1'b1;
    build(DA_GRP, SA_OK, 50, 70);          send("R5 group on", 1, 8'h21, 1);
    cfg_promisc = 1'b1;
    build(DA_MISS, SA_OK, 50, 64);         send("R6 promisc", 1, 8'h01, 1);
    build(DA_MISS, SA_OK, 50, 10);         send("R6 promisc short", 1, 8'h04, 1);
    cfg_promisc = 1'b0;
    build(station_addr, SA_OK, 50, 63);    send("R7 63 bytes", 1, 8'h04, 1);
    build(station_addr, SA_OK, 50, 3);     send("R7 3 bytes", 0, 8'h44, 1);
    build(station_addr, SA_OK, 50, 6);     send("R7 6 bytes", 1, 8'h04, 1);
    build(station_addr, SA_OK, 50, 1518);  send("R8 1518", 1, 8'h01, 1);
    build(station_addr, SA_OK, 50, 1519);  send("R8 1519", 1, 8'h08, 1);
    build(DA_BC, SA_OK, 50, 1519);         send("R8 bcast oversize", 1, 8'h28, 1);
    build(station_addr, SA_OK, 1500, 100); send("R9 len 1500", 1, 8'h01, 1);
    build(station_addr, SA_OK, 1501, 100); send("R9 len 1501", 1, 8'h10, 1);
    build(station_addr, SA_GRP, 50, 64);   send("R10 src group", 1, 8'h80, 1);
    build(station_addr, SA_OK, 50, 64);    send("R11 bad fcs", 1, 8'h02, 0);
    build(station_addr, SA_OK, 50, 40);    send("R11 frag and bad fcs", 1, 8'h06, 0);
    bp_en = 1'b1;
    build(station_addr, SA_OK, 50, 64);    send("R13 bp unicast", 1, 8'h01, 1);
    build(station_addr, SA_OK, 50, 6);     send("R13 bp 6 bytes", 1, 8'h04, 1);
    build(DA_MISS, SA_OK, 50, 64);         send("R13 bp miss", 0, 8'h40, 1);
    build(DA_BC, SA_OK, 50, 200);          send("R13 bp bcast", 1, 8'h21, 1);
    bp_en = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule